// File: doc/BRIEF.md
# Local Tick Timer

This block is a per-core timer that raises an interrupt after a programmable number of ticks, where a tick is itself a programmable number of input clocks. Two down-counters are chained. The first one divides the clock by the tick-buffer value. The second counts its expirations and sets a pending flag when it reaches the end of its count. Software programs both counts and the run bits through a simple single-cycle write port. It reads the registers and both live counters back through a combinational read port.

The two stages are enabled separately. In interval mode, the interrupt counter reloads after each expiry, so interrupts repeat until software clears the run bits. Without interval mode, the counter stops at zero after one expiry. Every write to the tick buffer, the interrupt buffer or the control register sets its own bit in a write-status register, and software clears that bit by writing 1 to it.

Top module: `local_tick_timer`

## Requirements
- R1: After reset, the tick buffer reads 1 and every other register reads 0: control, interrupt buffer, enable, pending, write status and interrupt counter. The irq output is low.
- R2: While the run bit (control bit 0) is set, the tick counter counts down one step per clock. It expires on the clock where it holds 1 (or 0) and then reloads from the tick buffer, so with buffer value T a tick occurs every T clocks. A write to the tick buffer also loads the tick counter.
- R3: On each tick, if the interrupt-run bit (control bit 1) is set and the interrupt counter is non-zero, the counter decrements. When it steps from 1, the pending flag is set. With counts T and N, loaded before the control write that starts both stages, pending rises N·T clocks after that write.
- R4: With the interval bit (control bit 2) set, the interrupt counter reloads from its buffer on expiry, and pending rises again every N·T clocks. With the interval bit clear, the counter stays at 0 and pending is not set again.
- R5: Clearing the run bit freezes both the tick counter and the interrupt counter.
- R6: With the run bit set and the interrupt-run bit clear, the tick counter keeps running and the interrupt counter holds its value.
- R7: A write to the interrupt buffer stores bits 30:0 as the count. If bit 31 of the same write is 1, the count is also loaded into the interrupt counter. If bit 31 is 0, the interrupt counter is unchanged.
- R8: In the write-status register, bit 0 is set by a tick-buffer write, bit 1 by an interrupt-buffer write and bit 3 by a control write. Writing 1 to a write-status bit clears only that bit.
- R9: irq is the pending flag gated by enable bit 0. Writing 1 to bit 0 of the pending register clears the flag.
- R10: The register addresses are: 0 tick buffer, 1 interrupt buffer, 2 control, 3 enable, 4 pending, 5 write status, 6 tick counter (read-only), 7 interrupt counter (read-only).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect on the clock edge that samples it, and its read-back is visible before the following edge. A pending rise is due exactly N·T edges after the control write that starts the counters. An enable write makes irq rise on that same edge. The bench numbers every edge. A driver queues the edge number at which each irq rise is due. A monitor sampling at the falling edge pops each rise and compares its edge number, and it reports any rise that was not queued. Frozen or held counters are checked by reading them back several cycles apart.

// File: rtl/lt_pkg.sv
`timescale 1ns/1ps
package lt_pkg;
  localparam int ADR_TICKBUF = 0;
  localparam int ADR_INTBUF  = 1;
  localparam int ADR_CTRL    = 2;
  localparam int ADR_ENABLE  = 3;
  localparam int ADR_PEND    = 4;
  localparam int ADR_WSTAT   = 5;
  localparam int ADR_TICKCNT = 6;
  localparam int ADR_INTCNT  = 7;

  localparam int WS_TICK = 0;
  localparam int WS_INT  = 1;
  localparam int WS_CTRL = 3;

  localparam int CB_RUN      = 0;
  localparam int CB_INTRUN   = 1;
  localparam int CB_INTERVAL = 2;

  typedef struct packed {
    logic loadTick;
    logic loadInt;
    logic tickRun;
    logic intRun;
    logic interval;
  } ltStrobe_t;
endpackage

// File: rtl/lt_count.sv
`timescale 1ns/1ps
module lt_count
  import lt_pkg::*;
#(
  parameter int TICK_W = 32,
  parameter int ICNT_W = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  ltStrobe_t         stb,
  input  logic [TICK_W-1:0] tickLoad,
  input  logic [ICNT_W-1:0] intLoad,
  input  logic [TICK_W-1:0] tickBuf,
  input  logic [ICNT_W-1:0] intBuf,
  output logic [TICK_W-1:0] tickCnt,
  output logic [ICNT_W-1:0] intCnt,
  output logic              expire
);
  logic tickWrap, intStep;

  assign tickWrap = stb.tickRun && (tickCnt <= TICK_W'(1));
  assign intStep  = tickWrap && stb.intRun && (intCnt != '0);
  assign expire   = intStep && (intCnt == ICNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN)            tickCnt <= TICK_W'(1);
    else if (stb.loadTick) tickCnt <= tickLoad;
    else if (tickWrap)    tickCnt <= tickBuf;
    else if (stb.tickRun) tickCnt <= tickCnt - TICK_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            intCnt <= '0;
    else if (stb.loadInt) intCnt <= intLoad;
    else if (expire)      intCnt <= stb.interval ? intBuf : '0;
    else if (intStep)     intCnt <= intCnt - ICNT_W'(1);
  end

  // R5: a stopped timer freezes the tick counter
  a_r5_tick_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.tickRun && !stb.loadTick) |=> $stable(tickCnt));
  // R5, R6: interrupt counter holds unless both stages run
  a_r6_int_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!(stb.tickRun && stb.intRun) && !stb.loadInt) |=> $stable(intCnt));
  // R4: one-shot expiry leaves the counter at zero
  a_r4_oneshot_zero: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !stb.interval && !stb.loadInt) |=> (intCnt == '0));
endmodule

// File: rtl/lt_ctrl.sv
`timescale 1ns/1ps
module lt_ctrl
  import lt_pkg::*;
#(
  parameter int TICK_W = 32,
  parameter int ICNT_W = 31,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [TICK_W-1:0] tickCnt,
  input  logic [ICNT_W-1:0] intCnt,
  input  logic              expire,
  output ltStrobe_t         stb,
  output logic [TICK_W-1:0] tickBuf,
  output logic [ICNT_W-1:0] intBuf,
  output logic              irq
);
  localparam int UPD_BIT = ICNT_W;

  logic [2:0] ctrlReg;
  logic       intEn, pending;
  logic [3:0] wstat;
  logic hitTick, hitInt, hitCtrl, hitEn, hitPend, hitWs;

  assign hitTick = wrEn && (wrAddr == ADDR_W'(ADR_TICKBUF));
  assign hitInt  = wrEn && (wrAddr == ADDR_W'(ADR_INTBUF));
  assign hitCtrl = wrEn && (wrAddr == ADDR_W'(ADR_CTRL));
  assign hitEn   = wrEn && (wrAddr == ADDR_W'(ADR_ENABLE));
  assign hitPend = wrEn && (wrAddr == ADDR_W'(ADR_PEND));
  assign hitWs   = wrEn && (wrAddr == ADDR_W'(ADR_WSTAT));

  always_comb begin
    stb.loadTick = hitTick;
    stb.loadInt  = hitInt && wrData[UPD_BIT];
    stb.tickRun  = ctrlReg[CB_RUN];
    stb.intRun   = ctrlReg[CB_INTRUN];
    stb.interval = ctrlReg[CB_INTERVAL];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickBuf <= TICK_W'(1);
      intBuf  <= '0;
      ctrlReg <= '0;
      intEn   <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (hitTick) tickBuf <= wrData[TICK_W-1:0];
      if (hitInt)  intBuf  <= wrData[ICNT_W-1:0];
      if (hitCtrl) ctrlReg <= wrData[2:0];
      if (hitEn)   intEn   <= wrData[0];
      pending <= (pending && !(hitPend && wrData[0])) || expire;
    end
  end

  // one write-status bit per tracked register
  localparam int NWS = 3;
  localparam int WS_POS [NWS] = '{WS_TICK, WS_INT, WS_CTRL};
  logic [NWS-1:0] wsSet;
  assign wsSet = {hitCtrl, hitInt, hitTick};

  generate
    for (genvar g = 0; g < NWS; g++) begin : g_ws
      always_ff @(posedge clk) begin
        if (!rstN) wstat[WS_POS[g]] <= 1'b0;
        else wstat[WS_POS[g]] <= (wstat[WS_POS[g]] && !(hitWs && wrData[WS_POS[g]])) || wsSet[g];
      end
    end
  endgenerate
  assign wstat[2] = 1'b0;

  assign irq = pending && intEn;

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_W'(ADR_TICKBUF): rdData = DATA_W'(tickBuf);
      ADDR_W'(ADR_INTBUF):  rdData = DATA_W'(intBuf);
      ADDR_W'(ADR_CTRL):    rdData = DATA_W'(ctrlReg);
      ADDR_W'(ADR_ENABLE):  rdData = DATA_W'(intEn);
      ADDR_W'(ADR_PEND):    rdData = DATA_W'(pending);
      ADDR_W'(ADR_WSTAT):   rdData = DATA_W'(wstat);
      ADDR_W'(ADR_TICKCNT): rdData = DATA_W'(tickCnt);
      ADDR_W'(ADR_INTCNT):  rdData = DATA_W'(intCnt);
      default:              rdData = '0;
    endcase
  end

  // R3: an expiry always leaves the pending flag set
  a_r3_pending_set: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> pending);
  // R8: a control write is reported in write-status bit 3
  a_r8_ctrl_wstat: assert property (@(posedge clk) disable iff (!rstN)
    hitCtrl |=> wstat[WS_CTRL]);
  // R9: a clear without a new expiry drops the pending flag
  a_r9_pend_clear: assert property (@(posedge clk) disable iff (!rstN)
    (hitPend && wrData[0] && !expire) |=> !pending);
endmodule

// File: rtl/local_tick_timer.sv
`timescale 1ns/1ps
module local_tick_timer
  import lt_pkg::*;
#(
  parameter int TICK_W = 32,
  parameter int ICNT_W = 31,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  ltStrobe_t         stb;
  logic [TICK_W-1:0] tickBuf, tickCnt;
  logic [ICNT_W-1:0] intBuf, intCnt;
  logic              expire;

  lt_ctrl #(.TICK_W(TICK_W), .ICNT_W(ICNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .tickCnt(tickCnt), .intCnt(intCnt),
    .expire(expire), .stb(stb), .tickBuf(tickBuf), .intBuf(intBuf), .irq(irq)
  );

  lt_count #(.TICK_W(TICK_W), .ICNT_W(ICNT_W)) u_count (
    .clk(clk), .rstN(rstN), .stb(stb),
    .tickLoad(wrData[TICK_W-1:0]), .intLoad(wrData[ICNT_W-1:0]),
    .tickBuf(tickBuf), .intBuf(intBuf),
    .tickCnt(tickCnt), .intCnt(intCnt), .expire(expire)
  );
endmodule

// File: tb/local_tick_timer_bench.sv
`timescale 1ns/1ps
module local_tick_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        irq;

  local_tick_timer u_local_tick_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int    cyc = 0;
  int    nChecks = 0;
  int    nFails = 0;
  bit    done = 0;
  int    expQ[$];
  string tagQ[$];
  logic  prevIrq = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitTo(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic expectRise(input int c, input string req);
    expQ.push_back(c);
    tagQ.push_back(req);
  endtask

  // monitor: every irq rise is compared with the queued edge number
  always @(negedge clk) begin
    if (rstN) begin
      if (irq && !prevIrq) begin
        nChecks++;
        if (expQ.size() == 0) begin
          nFails++;
          $display("FAIL R4: unexpected irq rise at edge %0d, expected none", cyc);
        end else begin
          automatic int    e = expQ.pop_front();
          automatic string t = tagQ.pop_front();
          if (e != cyc) begin
            nFails++;
            $display("FAIL %s: irq rose at edge %0d expected %0d", t, cyc, e);
          end
        end
      end
      prevIrq <= irq;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int w;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R10 reset values
    rd(0, v); check("R1 tick buffer", v, 32'd1);
    rd(2, v); check("R1 control", v, 32'd0);
    rd(5, v); check("R1 write status", v, 32'd0);
    rd(4, v); check("R1 pending", v, 32'd0);
    rd(7, v); check("R10 interrupt counter", v, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R7 / R8 buffer writes and write status
    wr(0, 32'd3);
    rd(5, v); check("R8 tick write sets bit0", v, 32'h1);
    wr(1, 32'd5);
    rd(7, v); check("R7 no update flag keeps counter", v, 32'd0);
    rd(1, v); check("R7 buffer stored", v, 32'd5);
    wr(1, 32'h8000_0002);
    rd(7, v); check("R7 update flag loads counter", v, 32'd2);
    rd(5, v); check("R8 bits 0 and 1", v, 32'h3);
    wr(5, 32'h2);
    rd(5, v); check("R8 clear bit1 only", v, 32'h1);
    wr(5, 32'h1);
    wr(3, 32'h1);

    // R2 / R3 / R4 interval mode, T=3 N=2
    wr(2, 32'h7);
    w = cyc;
    rd(5, v); check("R8 control write sets bit3", v, 32'h8);
    expectRise(w + 6, "R3");
    expectRise(w + 12, "R4");
    expectRise(w + 18, "R4");
    waitTo(w + 7);  wr(4, 32'h1);
    check("R9 clear drops irq", {31'd0, irq}, 32'd0);
    waitTo(w + 13); wr(4, 32'h1);
    waitTo(w + 19); wr(2, 32'h0);
    wr(4, 32'h1);

    // R5 freeze
    rd(6, v); rd(7, v2);
    repeat (5) @(negedge clk);
    begin
      logic [31:0] a2, b2;
      rd(6, a2); rd(7, b2);
      check("R5 tick counter frozen", a2, v);
      check("R5 interrupt counter frozen", b2, v2);
    end

    // R6 tick runs while interrupt counting is off
    wr(0, 32'd4);
    wr(1, 32'h8000_0003);
    wr(2, 32'h1);
    rd(6, v);
    @(negedge clk);
    rd(6, v2);
    check("R6 tick counter moving", {31'd0, v != v2}, 32'd1);
    repeat (20) @(negedge clk);
    rd(7, v); check("R6 interrupt counter held", v, 32'd3);
    wr(2, 32'h0);

    // R4 one-shot, T=2 N=3
    wr(0, 32'd2);
    wr(1, 32'h8000_0003);
    wr(2, 32'h3);
    w = cyc;
    expectRise(w + 6, "R2");
    waitTo(w + 30);
    rd(7, v); check("R4 one-shot counter at zero", v, 32'd0);
    rd(4, v); check("R3 pending set", v, 32'd1);
    wr(4, 32'h1);
    check("R9 clear drops irq", {31'd0, irq}, 32'd0);

    // R9 enable gating
    wr(3, 32'h0);
    wr(0, 32'd1);
    wr(1, 32'h8000_0001);
    repeat (4) @(negedge clk);
    rd(4, v); check("R9 pending while disabled", v, 32'd1);
    check("R9 irq masked", {31'd0, irq}, 32'd0);
    expectRise(cyc + 2, "R9");
    wr(3, 32'h1);
    check("R9 irq after enable", {31'd0, irq}, 32'd1);
    wr(4, 32'h1);
    wr(2, 32'h0);
    repeat (10) @(negedge clk);

    nChecks++;
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL R3: %0d irq rises missing, expected 0", expQ.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule